// File: doc/BRIEF.md
# Crosspoint Switch Control Register

This block is the digital control front end of a crosspoint switch with 16 inputs and 8 outputs. Routing words arrive either as one serial frame or as single-output writes on a small parallel bus. They collect in a load register and pass through a transfer stage. That stage is controlled by an update input. Each output's stored word is then decoded into a one-hot input select vector and an enable bit, which drive the analog matrix outside this block.

Each output owns a 5-bit slot. The upper bit enables the output and the lower four bits name the input it carries. In serial mode the load register shifts as one chain, and its top bit is brought out so that several blocks can be cascaded into a longer chain. In parallel mode an address picks one slot and only that slot is rewritten. While update is low, the transfer stage follows the load register on every clock. While update is high, the stage keeps its value, so a new map can be assembled without disturbing the live routes. An asynchronous active-low reset turns every output off at once.

Top module: `xpt_ctrl`

## Requirements
- R1: With ce_i high and par_mode_i low, each rising clk_i edge shifts sdi_i into bit 0 of the 40-bit load register and moves every bit up one place. Output k owns bits 5k+4..5k: bit 5k+4 is its enable and bits 5k+3..5k are its input number. The first of 40 serial bits therefore lands on output 7's enable, and the last lands on output 0's select bit 0.
- R2: sdo_o always equals bit 39 of the load register. During a serial load, the bits of the previous frame appear on sdo_o before each shift edge in the order in which they were sent.
- R3: With ce_i high and par_mode_i high, a rising edge writes pdata_i (bit 4 enable, bits 3..0 input number) into the slot of output paddr_i. All other slots keep their contents.
- R4: With ce_i low, the load register is unchanged in both modes.
- R5: On each rising edge with upd_i low, the transfer stage takes the load register contents as they were before that edge. The new routes are visible on the outputs right after that edge.
- R6: While upd_i is high, en_o and sel_o hold their value whatever happens in the load register.
- R7: An enabled output k drives en_o[k] high and sets exactly one bit of sel_o[16k+15:16k], the bit whose index is its input number.
- R8: An output whose stored enable bit is 0 drives en_o[k] low and sel_o[16k+15:16k] to all zeros.
- R9: Driving rst_ni low forces all en_o bits low and all of sel_o to zero without waiting for a clock edge. The load register is not cleared, so an update after reset restores the routes it holds.
- R10: While rst_ni is low, the outputs stay off even if upd_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, turns all outputs off |
| sdi_i | input | 1 | Serial data into load register bit 0 |
| sdo_o | output | 1 | Load register top bit, for cascading |
| pdata_i | input | 5 | Parallel slot word: bit 4 enable, bits 3..0 input number |
| paddr_i | input | 3 | Output addressed by a parallel write |
| par_mode_i | input | 1 | 0 = serial shift, 1 = parallel slot write |
| ce_i | input | 1 | Load enable, active high |
| upd_i | input | 1 | 0 = transfer each clock, 1 = hold |
| sel_o | output | 128 | One-hot input select, output k at bits 16k+15..16k |
| en_o | output | 8 | Output enables |

## Verification
The bench builds the block with its default 16-by-8 geometry, which gives a 40-bit chain, a 3-bit address and a full 16-way decode. With this geometry, every input number from 0 to 15 and every output address can be reached. A full 40-bit frame can also be pushed through the chain so that the previous frame emerges on the cascade output. The default width also lets a mid-frame update be told apart from a clean one, and lets a reset applied between edges be observed while update is held transparent.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic {
    LOAD_SER = 1'b0,
    LOAD_PAR = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_load_reg.sv
module xpt_load_reg
  import xpt_pkg::*;
#(
  parameter int N_OUT   = 8,
  parameter int SLOT_W  = 5,
  parameter int ADDR_W  = 3,
  localparam int FRAME_W = N_OUT * SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sdi_i,
  input  load_mode_e         mode_i,
  input  logic               ce_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [SLOT_W-1:0]  pdata_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sdo_o
);
  logic [FRAME_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (ce_i) begin
      if (mode_i == LOAD_SER) begin
        sr_d = {sr_q[FRAME_W-2:0], sdi_i};
      end else begin
        for (int k = 0; k < N_OUT; k++) begin
          if (paddr_i == ADDR_W'(k)) sr_d[k*SLOT_W +: SLOT_W] = pdata_i;
        end
      end
    end
  end

  // not reset: the routing map survives an output-off reset
  always_ff @(posedge clk_i) sr_q <= sr_d;

  assign frame_o = sr_q;
  assign sdo_o   = sr_q[FRAME_W-1];

  a_r2_cascade: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && mode_i == LOAD_SER) |=> sdo_o == $past(frame_o[FRAME_W-2]));

  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && mode_i == LOAD_SER) |=> frame_o[0] == $past(sdi_i));

  a_r4_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(frame_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_slot_chk
    a_r3_other_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_i && mode_i == LOAD_PAR && paddr_i != ADDR_W'(k))
        |=> $stable(frame_o[k*SLOT_W +: SLOT_W]));
    a_r3_addr_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_i && mode_i == LOAD_PAR && paddr_i == ADDR_W'(k))
        |=> frame_o[k*SLOT_W +: SLOT_W] == $past(pdata_i));
  end
endmodule

// File: rtl/xpt_xfer_latch.sv
module xpt_xfer_latch #(
  parameter int N_OUT  = 8,
  parameter int SEL_W  = 4,
  localparam int SLOT_W  = SEL_W + 1,
  localparam int FRAME_W = N_OUT * SLOT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         upd_i,
  input  logic [FRAME_W-1:0]           frame_i,
  output logic [N_OUT-1:0]             en_q_o,
  output logic [N_OUT-1:0][SEL_W-1:0]  sel_q_o
);
  logic [N_OUT-1:0]            frame_en;
  logic [N_OUT-1:0][SEL_W-1:0] frame_sel;
  logic [N_OUT-1:0]            en_q;
  logic [N_OUT-1:0][SEL_W-1:0] sel_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_split
    assign frame_en[k]  = frame_i[k*SLOT_W + SEL_W];
    assign frame_sel[k] = frame_i[k*SLOT_W +: SEL_W];
  end

  // synchronous stand-in for a transparent-low latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (!upd_i) en_q <= frame_en;
  end

  always_ff @(posedge clk_i) begin
    if (!upd_i) sel_q <= frame_sel;
  end

  assign en_q_o  = en_q;
  assign sel_q_o = sel_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> ($stable(en_q_o) && $stable(sel_q_o)));

  a_r10_reset_off: assert property (@(posedge clk_i)
    !rst_ni |-> en_q_o == '0);
endmodule

// File: rtl/xpt_slot_dec.sv
module xpt_slot_dec #(
  parameter int N_IN  = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_IN-1:0]  onehot_o,
  output logic             en_o
);
  for (genvar j = 0; j < N_IN; j++) begin : g_dec
    assign onehot_o[j] = en_i && (sel_i == SEL_W'(j));
  end
  assign en_o = en_i;

  a_r8_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> onehot_o == '0);

  a_r7_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && int'(sel_i) < N_IN) |-> $countones(onehot_o) == 1);
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
#(
  parameter int N_IN  = 16,
  parameter int N_OUT = 8,
  localparam int SEL_W   = $clog2(N_IN),
  localparam int SLOT_W  = SEL_W + 1,
  localparam int ADDR_W  = $clog2(N_OUT),
  localparam int FRAME_W = N_OUT * SLOT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  input  logic [SLOT_W-1:0]       pdata_i,
  input  logic [ADDR_W-1:0]       paddr_i,
  input  logic                    par_mode_i,
  input  logic                    ce_i,
  input  logic                    upd_i,
  output logic [N_OUT*N_IN-1:0]   sel_o,
  output logic [N_OUT-1:0]        en_o
);
  load_mode_e                  mode;
  logic [FRAME_W-1:0]          frame;
  logic [N_OUT-1:0]            en_q;
  logic [N_OUT-1:0][SEL_W-1:0] sel_q;

  assign mode = par_mode_i ? LOAD_PAR : LOAD_SER;

  xpt_load_reg #(
    .N_OUT (N_OUT),
    .SLOT_W(SLOT_W),
    .ADDR_W(ADDR_W)
  ) u_load (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdi_i  (sdi_i),
    .mode_i (mode),
    .ce_i   (ce_i),
    .paddr_i(paddr_i),
    .pdata_i(pdata_i),
    .frame_o(frame),
    .sdo_o  (sdo_o)
  );

  xpt_xfer_latch #(
    .N_OUT(N_OUT),
    .SEL_W(SEL_W)
  ) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd_i),
    .frame_i(frame),
    .en_q_o (en_q),
    .sel_q_o(sel_q)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    xpt_slot_dec #(
      .N_IN (N_IN),
      .SEL_W(SEL_W)
    ) u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q[k]),
      .sel_i   (sel_q[k]),
      .onehot_o(sel_o[k*N_IN +: N_IN]),
      .en_o    (en_o[k])
    );
  end

  a_r9_reset_outputs: assert property (@(posedge clk_i)
    !rst_ni |-> (en_o == '0 && sel_o == '0));
endmodule

// File: tb/sim_xpt_ctrl.sv
module sim_xpt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 16;
  localparam int N_OUT = 8;
  localparam int FW = 40;

  // parallel write vectors: {addr[2:0], en, sel[3:0]}
  localparam logic [7:0] PW_TAB [8] = '{
    {3'd2, 5'b1_0101}, {3'd5, 5'b1_1111}, {3'd0, 5'b1_0000}, {3'd7, 5'b0_1010},
    {3'd3, 5'b1_1001}, {3'd6, 5'b1_0011}, {3'd1, 5'b0_0000}, {3'd4, 5'b1_1110}
  };

  logic clk = 0, rst_ni = 0, sdi = 0, par_mode = 0, ce = 0, upd = 1;
  logic [4:0] pdata = '0;
  logic [2:0] paddr = '0;
  logic sdo;
  logic [N_OUT*N_IN-1:0] sel;
  logic [N_OUT-1:0] en;

  int n_chk = 0, n_err = 0;
  logic [FW-1:0] model;
  logic [FW-1:0] f1, f2;
  logic [FW-1:0] got_sdo;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sdi_i(sdi), .sdo_o(sdo),
    .pdata_i(pdata), .paddr_i(paddr), .par_mode_i(par_mode),
    .ce_i(ce), .upd_i(upd), .sel_o(sel), .en_o(en)
  );

  function automatic logic [FW-1:0] mk_frame(input int seed);
    logic [FW-1:0] f;
    for (int k = 0; k < N_OUT; k++) begin
      if (seed == 1) f[k*5 +: 5] = {k != 3, 4'(15 - 2*k)};
      else           f[k*5 +: 5] = {k != 6, 4'(k*3)};
    end
    return f;
  endfunction

  function automatic logic [16:0] exp_slot(input logic [4:0] s);
    return {s[4], s[4] ? (16'd1 << s[3:0]) : 16'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input int k, input string req);
    logic [16:0] a, e;
    a = {en[k], sel[k*N_IN +: N_IN]};
    e = exp_slot(model[k*5 +: 5]);
    chk(a === e, req, 128'(a), 128'(e));
  endtask

  task automatic chk_all(input string req);
    for (int k = 0; k < N_OUT; k++) chk_out(k, req);
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ser_load(input logic [FW-1:0] f);
    par_mode = 0;
    ce = 1;
    for (int j = 0; j < FW; j++) begin
      sdi = f[FW-1-j];
      got_sdo[FW-1-j] = sdo;
      cyc();
    end
    ce = 0;
    model = f;
  endtask

  task automatic par_write(input logic [2:0] a, input logic [4:0] d);
    par_mode = 1;
    ce = 1;
    paddr = a;
    pdata = d;
    cyc();
    ce = 0;
    model[a*5 +: 5] = d;
  endtask

  task automatic pulse_upd;
    upd = 0;
    cyc();
    upd = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    f1 = mk_frame(1);
    f2 = mk_frame(2);
    @(negedge clk);
    cyc();
    cyc();
    // R9: reset state
    chk(en === '0 && sel === '0, "R9 reset state", 128'({en, sel}), 128'(0));
    rst_ni = 1;
    cyc();

    // R1, R6: serial load while holding
    ser_load(f1);
    chk(en === '0 && sel === '0, "R6 hold during serial load", 128'({en, sel}), 128'(0));
    chk(sdo === f1[39], "R2 sdo is top bit", 128'(sdo), 128'(f1[39]));
    pulse_upd();
    chk_all("R1/R7/R8 serial frame 1");

    // R2: cascade of previous frame
    ser_load(f2);
    chk(got_sdo === f1, "R2 cascade order", 128'(got_sdo), 128'(f1));
    model = f1;
    chk_all("R6 hold after frame 2 load");
    model = f2;
    pulse_upd();
    chk_all("R1/R7/R8 serial frame 2");

    // R4: ce low blocks both modes
    ce = 0;
    par_mode = 0;
    for (int j = 0; j < 10; j++) begin
      sdi = j[0];
      cyc();
    end
    par_mode = 1;
    paddr = 3'd6;
    pdata = 5'b1_0001;
    cyc();
    pulse_upd();
    chk_all("R4 ce low no load");

    // R3, R7, R8: table of parallel writes
    for (int i = 0; i < 8; i++) begin
      par_write(PW_TAB[i][7:5], PW_TAB[i][4:0]);
      pulse_upd();
      chk_out(int'(PW_TAB[i][7:5]), "R3/R7/R8 parallel slot");
    end
    chk_all("R3 untouched slots");

    // R5: transparent path lags the load by one edge
    upd = 0;
    model[2*5 +: 5] = 5'b1_1100;
    par_mode = 1; ce = 1; paddr = 3'd2; pdata = 5'b1_1100;
    cyc();
    ce = 0;
    chk({en[2], sel[2*N_IN +: N_IN]} === exp_slot(5'b1_0101), "R5 old value after write edge",
        128'({en[2], sel[2*N_IN +: N_IN]}), 128'(exp_slot(5'b1_0101)));
    cyc();
    chk_out(2, "R5 new value one edge later");
    upd = 1;

    // R9, R10: asynchronous reset between edges, update held transparent
    #1 rst_ni = 0;
    #1 chk(en === '0 && sel === '0, "R9 async reset off", 128'({en, sel}), 128'(0));
    upd = 0;
    cyc();
    cyc();
    chk(en === '0 && sel === '0, "R10 off while reset and upd low", 128'({en, sel}), 128'(0));
    upd = 1;
    rst_ni = 1;
    cyc();
    chk(en === '0, "R6 hold after reset release", 128'(en), 128'(0));
    pulse_upd();
    chk_all("R9 map kept through reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule